// File: doc/BRIEF.md
# Thermal Alarm with Consecutive-Fault Qualification

This block watches a stream of 9-bit two's-complement temperature samples (0.5 degree per LSB) and decides when an over-temperature alarm must be raised or dropped. Each sample that arrives with its valid strobe is compared, as a signed number, against an upper trip threshold and a lower release threshold. An alarm transition happens only after a programmable number of consecutive qualifying samples, which filters out noise. The number is taken from a 2-bit selector.

Two behaviours are available. In thermostat (comparator) mode the alarm follows the temperature with hysteresis. In latched (interrupt) mode a threshold crossing sets the alarm, which stays set until a register read strobe clears it. The next crossing that can set it again is the crossing of the opposite threshold. A shutdown bit freezes evaluation. The alarm drives an open-drain pin through an enable whose sense depends on a polarity bit.

Top module: `thermal_alarm`

## Requirements
- R1: The sample and both thresholds are 9-bit two's complement, with 0.5 degree per LSB (for example 0x032 is +25, 0x1FF is -0.5, 0x192 is -55). All comparisons are signed.
- R2: Comparisons are strict. A sample equal to the trip threshold never counts toward raising the alarm. A sample equal to the release threshold never counts toward dropping it.
- R3: cfgCtrl[4:3] sets the number of consecutive qualifying samples needed for a transition: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 6. Any evaluated sample that does not qualify restarts the count from zero. The count also restarts after every transition.
- R4: With cfgCtrl[1]=0 (thermostat), samples above the trip threshold raise an inactive alarm. Samples below the release threshold drop an active alarm.
- R5: With cfgCtrl[1]=1 (latched), a qualifying crossing sets the alarm. The alarm then stays set, ignoring samples, until regRead is high in a cycle. regRead has no effect while the alarm is clear or in thermostat mode.
- R6: In latched mode the crossings alternate. The first crossing looks for samples above the trip threshold. After each crossing, the next crossing looks for the other threshold: below the release threshold after a high crossing, above the trip threshold after a low one.
- R7: While cfgCtrl[0]=1 (shutdown), no sample is evaluated and the consecutive count is cleared. In latched mode, shutdown also clears the alarm. In thermostat mode the alarm level is held.
- R8: pinPullDown is 1 when the pin must be low. With cfgCtrl[2]=0 (active low) this is the case while the alarm is active. With cfgCtrl[2]=1 (active high) it is the case while the alarm is inactive.
- R9: A sample presented with sampleValid in one cycle updates alarmActive at the next rising clock edge. alarmActive does not change before that edge.
- R10: In latched mode, if regRead and a valid sample fall in the same cycle while the alarm is set, the alarm clears and that sample is not evaluated.
- R11: After reset the alarm is inactive, the count is zero, and latched mode first looks for samples above the trip threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A new sample is present this cycle |
| sample | input | 9 | Temperature sample, two's complement |
| overLimit | input | 9 | Trip threshold, two's complement |
| hystLimit | input | 9 | Release threshold, two's complement |
| cfgCtrl | input | 5 | [0] shutdown, [1] latched mode, [2] active high, [4:3] fault count select |
| regRead | input | 1 | Register read strobe that clears a latched alarm |
| alarmActive | output | 1 | Alarm state, independent of polarity |
| pinPullDown | output | 1 | Open-drain enable: 1 pulls the alarm pin low |

## Verification
The two functions that can fall in the same cycle are a latched-alarm clear by regRead and the evaluation of a new sample. The bench provokes this by presenting a below-release sample together with regRead while the alarm is latched and the block is looking for the low crossing. If that sample were evaluated, it would set the alarm again at once. The bench therefore judges the case by requiring the alarm to be clear after that edge. Randomised runs in latched mode also mix reads with samples in every fault-count setting, and compare the result against an arithmetic model edge by edge.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;

  localparam int CNT_W = 3;

  typedef struct packed {
    logic evalEn;
    logic seekLow;
    logic clearCnt;
  } alarm_strobe_t;

  function automatic logic [CNT_W-1:0] faultsNeeded(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/thermal_alarm_datapath.sv
module thermal_alarm_datapath
  import thermal_alarm_pkg::*;
#(
  parameter int TEMP_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] sample,
  input  logic [TEMP_W-1:0] overLimit,
  input  logic [TEMP_W-1:0] hystLimit,
  input  logic [1:0]        queueSel,
  input  alarm_strobe_t     strobes,
  output logic              fire
);

  logic signed [TEMP_W-1:0] sampleS, overS, hystS;
  logic                     qualify;
  logic [CNT_W-1:0]         faultCnt, cntInc, need;

  assign sampleS = $signed(sample);
  assign overS   = $signed(overLimit);
  assign hystS   = $signed(hystLimit);

  // strict signed comparisons against the threshold being watched
  assign qualify = strobes.seekLow ? (sampleS < hystS) : (sampleS > overS);
  assign need    = faultsNeeded(queueSel);
  assign cntInc  = faultCnt + 3'd1;
  assign fire    = strobes.evalEn && qualify && (cntInc >= need);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultCnt <= '0;
    end else if (strobes.clearCnt) begin
      faultCnt <= '0;
    end else if (strobes.evalEn) begin
      faultCnt <= (qualify && !fire) ? cntInc : '0;
    end
  end

  assert_shutdown_clears_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> faultCnt == '0);

  assert_count_holds_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.evalEn && !strobes.clearCnt) |=> $stable(faultCnt));

  assert_miss_restarts_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalEn && !qualify && !strobes.clearCnt) |=> faultCnt == '0);

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    faultCnt <= 3'd5);

endmodule

// File: rtl/thermal_alarm_control.sv
module thermal_alarm_control
  import thermal_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic          cfgShutdown,
  input  logic          cfgIntMode,
  input  logic          regRead,
  input  logic          fire,
  output alarm_strobe_t strobes,
  output logic          alarmActive
);

  logic alarmQ, armLowQ, latched;

  assign latched          = cfgIntMode && alarmQ;
  assign strobes.evalEn   = sampleValid && !cfgShutdown && !latched;
  assign strobes.seekLow  = cfgIntMode ? armLowQ : alarmQ;
  assign strobes.clearCnt = cfgShutdown;
  assign alarmActive      = alarmQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmQ  <= 1'b0;
      armLowQ <= 1'b0;
    end else if (cfgShutdown) begin
      if (cfgIntMode) alarmQ <= 1'b0;
    end else if (latched) begin
      if (regRead) alarmQ <= 1'b0;
    end else if (fire) begin
      if (cfgIntMode) begin
        alarmQ  <= 1'b1;
        armLowQ <= ~armLowQ;
      end else begin
        alarmQ  <= ~alarmQ;
      end
    end
  end

  assert_thermostat_needs_event_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgIntMode && !fire) |=> $stable(alarmQ));

  assert_read_clears_latched_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIntMode && alarmQ && regRead) |=> !alarmQ);

  assert_latched_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIntMode && alarmQ && !regRead && !cfgShutdown) |=> alarmQ);

  assert_shutdown_clears_latched_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIntMode && cfgShutdown) |=> !alarmQ);

  assert_no_eval_when_latched_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIntMode && alarmQ) |-> !fire);

endmodule

// File: rtl/thermal_alarm.sv
module thermal_alarm
  import thermal_alarm_pkg::*;
#(
  parameter int TEMP_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sample,
  input  logic [TEMP_W-1:0] overLimit,
  input  logic [TEMP_W-1:0] hystLimit,
  input  logic [4:0]        cfgCtrl,
  input  logic              regRead,
  output logic              alarmActive,
  output logic              pinPullDown
);

  alarm_strobe_t strobes;
  logic          fire;

  thermal_alarm_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .cfgShutdown (cfgCtrl[0]),
    .cfgIntMode  (cfgCtrl[1]),
    .regRead     (regRead),
    .fire        (fire),
    .strobes     (strobes),
    .alarmActive (alarmActive)
  );

  thermal_alarm_datapath #(.TEMP_W(TEMP_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .sample    (sample),
    .overLimit (overLimit),
    .hystLimit (hystLimit),
    .queueSel  (cfgCtrl[4:3]),
    .strobes   (strobes),
    .fire      (fire)
  );

  // open-drain enable: pull low when the pin level must be 0
  assign pinPullDown = alarmActive ^ cfgCtrl[2];

endmodule

// File: tb/test_thermal_alarm.sv
module test_thermal_alarm;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sampleValid;
  logic [8:0] sample;
  logic [8:0] overLimit, hystLimit;
  logic [4:0] cfgCtrl;
  logic       regRead;
  logic       alarmActive, pinPullDown;

  always #5 clk = ~clk;

  thermal_alarm #(.TEMP_W(9)) i_thermal_alarm (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sample(sample),
    .overLimit(overLimit), .hystLimit(hystLimit), .cfgCtrl(cfgCtrl),
    .regRead(regRead), .alarmActive(alarmActive), .pinPullDown(pinPullDown)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference state derived from the requirements
  bit mAlarm, mArmLow;
  int mCnt, tos, hyst;
  int unsigned seed = 32'h1234_5678;

  function automatic int toSigned(input logic [8:0] v);
    return v[8] ? int'(v) - 512 : int'(v);
  endfunction

  function automatic int needOf(input logic [1:0] q);
    case (q)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 6;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setLimits(input int t, input int h);
    overLimit = t[8:0];
    hystLimit = h[8:0];
    tos  = t;
    hyst = h;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; regRead = 1'b0; cfgCtrl = '0; sample = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mAlarm = 0; mArmLow = 0; mCnt = 0;
  endtask

  // one clock edge with the given inputs; called at a falling edge
  task automatic step(input string req, input logic [4:0] cfg, input bit v,
                      input int s, input bit rd);
    int sv;
    bit low, q;
    cfgCtrl = cfg; sampleValid = v; sample = s[8:0]; regRead = rd;
    #1;
    check("R9", "alarm before edge", int'(alarmActive), int'(mAlarm));
    @(posedge clk);
    sv = toSigned(s[8:0]);
    if (cfg[0]) begin
      mCnt = 0;
      if (cfg[1]) mAlarm = 0;
    end else if (cfg[1] && mAlarm) begin
      if (rd) mAlarm = 0;
    end else if (v) begin
      low = cfg[1] ? mArmLow : mAlarm;
      q   = low ? (sv < hyst) : (sv > tos);
      if (q) begin
        mCnt++;
        if (mCnt >= needOf(cfg[4:3])) begin
          mCnt = 0;
          if (cfg[1]) begin mAlarm = 1; mArmLow = !mArmLow; end
          else mAlarm = !mAlarm;
        end
      end else begin
        mCnt = 0;
      end
    end
    @(negedge clk);
    sampleValid = 1'b0; regRead = 1'b0;
    check(req, "alarmActive", int'(alarmActive), int'(mAlarm));
    check("R8", "pinPullDown", int'(pinPullDown), cfg[2] ? int'(!mAlarm) : int'(mAlarm));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sampleValid = 1'b0; regRead = 1'b0; cfgCtrl = '0; sample = '0;
    setLimits(160, 150);
    doReset();

    // R11: reset state, both polarities
    check("R11", "alarm after reset", int'(alarmActive), 0);
    check("R11", "pin after reset, active low", int'(pinPullDown), 0);
    cfgCtrl = 5'b00100; #1;
    check("R11", "pin after reset, active high", int'(pinPullDown), 1);
    cfgCtrl = '0;

    // R1: every sample value against positive thresholds, ascending
    for (int i = 0; i < 512; i++) step("R1", 5'b00000, 1, i, 0);

    // R1: every sample value against negative thresholds, scrambled order
    doReset();
    setLimits(-10, -20);
    for (int i = 0; i < 512; i++) step("R1", 5'b00000, 1, (i * 37) % 512, 0);

    // R2: equality at both thresholds
    doReset();
    setLimits(160, 150);
    step("R2", 5'b00000, 1, 160, 0);
    check("R2", "equal trip no alarm", int'(alarmActive), 0);
    step("R2", 5'b00000, 1, 161, 0);
    step("R2", 5'b00000, 1, 150, 0);
    check("R2", "equal release holds", int'(alarmActive), 1);
    step("R2", 5'b00000, 1, 149, 0);

    // R3: four consecutive needed, a miss restarts the count
    doReset();
    for (int i = 0; i < 3; i++) step("R3", 5'b10000, 1, 170, 0);
    step("R3", 5'b10000, 1, 155, 0);
    for (int i = 0; i < 3; i++) step("R3", 5'b10000, 1, 170, 0);
    check("R3", "three after miss", int'(alarmActive), 0);
    step("R3", 5'b10000, 1, 170, 0);
    check("R3", "fourth raises", int'(alarmActive), 1);
    for (int i = 0; i < 3; i++) step("R4", 5'b10000, 1, 140, 0);
    step("R4", 5'b10000, 1, 150, 0);
    for (int i = 0; i < 3; i++) step("R4", 5'b10000, 1, 140, 0);
    check("R4", "three lows after equal", int'(alarmActive), 1);
    step("R4", 5'b10000, 1, 140, 0);
    check("R4", "fourth low releases", int'(alarmActive), 0);

    // R3, R4, R5, R8: every count, both modes, mixed reads
    for (int q = 0; q < 4; q++) begin
      for (int m = 0; m < 2; m++) begin
        logic [4:0] cfg;
        cfg = {q[1:0], q[0] ^ m[0], m[0], 1'b0};
        doReset();
        for (int k = 0; k < 80; k++) begin
          seed = seed * 32'd1103515245 + 32'd12345;
          step(m == 1 ? "R5" : "R4", cfg, seed[20] | seed[21], 140 + int'((seed >> 8) % 31),
               m == 1 && seed[24] && seed[25]);
        end
      end
    end

    // R5, R6: latched mode with alternating crossings
    doReset();
    step("R6", 5'b00010, 1, 170, 0);
    check("R6", "high crossing latches", int'(alarmActive), 1);
    step("R5", 5'b00010, 1, 140, 0);
    check("R5", "latched ignores samples", int'(alarmActive), 1);
    step("R5", 5'b00010, 0, 0, 1);
    check("R5", "read clears", int'(alarmActive), 0);
    step("R6", 5'b00010, 1, 170, 0);
    check("R6", "high ignored after high crossing", int'(alarmActive), 0);
    step("R6", 5'b00010, 1, 140, 0);
    check("R6", "low crossing latches", int'(alarmActive), 1);
    step("R5", 5'b00010, 0, 0, 1);
    step("R5", 5'b00010, 0, 0, 1);
    check("R5", "read with alarm clear", int'(alarmActive), 0);
    step("R6", 5'b00010, 1, 170, 0);
    check("R6", "high crossing again", int'(alarmActive), 1);

    // R10: read and sample in the same cycle while latched
    step("R10", 5'b00010, 1, 140, 1);
    check("R10", "same-cycle sample ignored", int'(alarmActive), 0);
    step("R10", 5'b00010, 1, 140, 0);
    check("R10", "next low sample evaluated", int'(alarmActive), 1);

    // R7: shutdown holds thermostat alarm, clears latched alarm, clears count
    doReset();
    step("R7", 5'b00000, 1, 170, 0);
    for (int i = 0; i < 3; i++) step("R7", 5'b00001, 1, 100, 0);
    check("R7", "thermostat alarm held in shutdown", int'(alarmActive), 1);
    step("R7", 5'b00000, 1, 100, 0);
    doReset();
    step("R7", 5'b00010, 1, 170, 0);
    step("R7", 5'b00011, 0, 0, 0);
    check("R7", "latched alarm cleared by shutdown", int'(alarmActive), 0);
    doReset();
    step("R7", 5'b01000, 1, 170, 0);
    step("R7", 5'b01001, 1, 170, 0);
    step("R7", 5'b01000, 1, 170, 0);
    check("R7", "count cleared by shutdown", int'(alarmActive), 0);
    step("R7", 5'b01000, 1, 170, 0);
    check("R7", "second sample after shutdown", int'(alarmActive), 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule